// File: doc/BRIEF.md
# Phased Subpattern Sequence Confirmer

This block is the second stage of a split-pattern string matcher. An earlier stage scans a byte stream and reports two things for every character. The first is a quotient index with a hit flag, which says that a fixed-length subpattern of `PHASES` characters ended on that character. The second is a set of remnant flags, one per target pattern, which say that the pattern's short tail ended on that character. A long target pattern counts as found only when three conditions hold. Its subpatterns must have arrived in the right order. Consecutive subpatterns must be exactly `PHASES` characters apart. Its remnant must end a fixed number of characters after the last subpattern, and that number is always smaller than `PHASES`.

A pattern can begin at any character offset, so the block keeps `PHASES` independent sequence automata, one per phase. A phase counter advances on each accepted character. Only the automaton that owns the current phase steps, and it steps by looking up a loaded transition table keyed by its state and the incoming index. Every other automaton holds its state, so each state stays valid for `PHASES` characters. Each pattern has a loaded remnant length. The block uses it to choose the phase whose held state lines up with the remnant end. It then tests that state against a loaded per-state pattern mask and ANDs the result with the remnant flag. The results of all patterns are ORed into a registered hit vector that comes with a valid strobe, one cycle after the character.

Top module: `phased_seq_confirm`

## Requirements
- R1: While reset is low at a clock edge, `hit_valid` and `hit_vec` become 0, the phase counter returns to phase 0 and every phase automaton returns to state 0.
- R2: The phase counter advances by one on each accepted character (`char_valid` high and `sos` low), wraps from `PHASES-1` to 0, and does not move on idle cycles.
- R3: On an accepted character, only the automaton of the current phase may change state. All other automata keep their state.
- R4: The stepping automaton loads the transition table entry at address {state, qidx} when `qhit` is high, and loads state 0 when `qhit` is low.
- R5: For an accepted character, bit p of the next `hit_vec` is set when `rem_hit[p]` is high and the mask of the state held by phase (current phase − L_p) mod `PHASES` has bit p set. Here L_p is pattern p's loaded remnant length.
- R6: A remnant flag alone confirms nothing when the selected state's mask lacks that pattern. A pattern whose remnant length is 0 or at least `PHASES` is never confirmed.
- R7: Subpattern hits whose spacing is not a multiple of `PHASES` land in different phases and do not confirm a pattern.
- R8: A cycle with `sos` high clears the phase counter and all automaton states, ignores any character in that cycle, and yields `hit_valid` = 0 on the next cycle.
- R9: When several patterns are confirmed by the same character, possibly from different phases, their bits are ORed into one `hit_vec`.
- R10: `hit_valid` is high exactly in the cycle after each accepted character. One character is accepted every cycle, with a fixed latency of one cycle.
- R11: Table writes use `cfg_sel`: 0 writes the transition entry at `cfg_addr` = {state, qidx} with `cfg_data[ST_W-1:0]`; 1 writes the mask of state `cfg_addr[ST_W-1:0]` with `cfg_data[NPAT-1:0]`; 2 writes the remnant length of pattern `cfg_addr[log2 NPAT-1:0]` with `cfg_data[PH_W-1:0]`; 3 writes nothing. Writes never raise `hit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sos | input | 1 | Start of stream: clears phase and automaton state |
| char_valid | input | 1 | A character's first-stage results are present |
| qhit | input | 1 | A subpattern ended on this character |
| qidx | input | QIDX_W | Quotient index of that subpattern |
| rem_hit | input | NPAT | Per-pattern remnant-end flags |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select (R11) |
| cfg_addr | input | ST_W+QIDX_W | Table entry address |
| cfg_data | input | max(NPAT,ST_W) | Table write data |
| hit_valid | output | 1 | Result strobe, one cycle after each accepted character |
| hit_vec | output | NPAT | Confirmed-pattern vector |

## Verification
Two confirmations can fall on the same character. One comes from a pattern with remnant length 2, whose sequence lives in one phase. The other comes from a pattern with remnant length 1, whose sequence lives in the neighbouring phase. The bench provokes this by placing single-subpattern sequences in two adjacent phases and then raising both remnant flags on one character. It judges the result by requiring exactly both bits in the single result that follows. A long pseudo-random stream is also compared cycle by cycle against a phase model kept in the bench. That stream mixes idle cycles, stream restarts and overlapping sequences, so coincident hits and phase wrap-around occur many times.

// File: rtl/pc_pkg.sv
// Shared definitions for the phased sequence confirmer.
// Assumes table select codes are fixed by the configuration contract.
package pc_pkg;
    typedef enum logic [1:0] {
        CFG_TRANS = 2'd0,
        CFG_PMASK = 2'd1,
        CFG_RLEN  = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/pc_cfg_tables.sv
// Loaded tables: sequence transitions, per-state pattern masks, remnant lengths.
// Assumes writes come from a configuration path. One transition read port is
// enough because only one phase steps per character.
module pc_cfg_tables
    import pc_pkg::*;
#(
    parameter int QIDX_W = 3,
    parameter int ST_W   = 2,
    parameter int NPAT   = 4,
    parameter int PH_W   = 2,
    parameter int DW     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [1:0]                     sel,
    input  logic [ST_W+QIDX_W-1:0]         addr,
    input  logic [DW-1:0]                  data,
    input  logic [ST_W+QIDX_W-1:0]         tr_addr,
    output logic [ST_W-1:0]                tr_next,
    output logic [(1<<ST_W)-1:0][NPAT-1:0] pmask,
    output logic [NPAT-1:0][PH_W-1:0]      rlen
);
    localparam int TR_DEPTH = 1 << (ST_W + QIDX_W);
    localparam int PAT_AW   = (NPAT > 1) ? $clog2(NPAT) : 1;

    logic [ST_W-1:0] trans [TR_DEPTH];
    cfg_sel_e        sel_e;

    assign sel_e   = cfg_sel_e'(sel);
    assign tr_next = trans[tr_addr];

    // Transition table write and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TR_DEPTH; i++) trans[i] <= '0;
        end else if (we && sel_e == CFG_TRANS) begin
            trans[addr] <= data[ST_W-1:0];
        end
    end

    // Pattern mask and remnant length write and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmask <= '0;
            rlen  <= '0;
        end else if (we && sel_e == CFG_PMASK) begin
            pmask[addr[ST_W-1:0]] <= data[NPAT-1:0];
        end else if (we && sel_e == CFG_RLEN) begin
            rlen[addr[PAT_AW-1:0]] <= data[PH_W-1:0];
        end
    end
endmodule

// File: rtl/pc_phase_ctr.sv
// Character phase counter, 0..PHASES-1, advanced by accepted characters.
// Assumes clr (start of stream) has priority over advance.
module pc_phase_ctr #(
    parameter int PHASES = 3,
    parameter int PH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    output logic [PH_W-1:0] ph
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    // Count accepted characters modulo PHASES.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ph <= '0;
        else if (adv)      ph <= (ph == LAST) ? '0 : ph + 1'b1;
    end

    // R2
    ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= LAST);
    // R2
    ph_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ph == LAST) |=> ph == '0);
    // R2
    ph_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(ph));
endmodule

// File: rtl/pc_phase_unit.sv
// One phase's sequence automaton state; steps only on its own phase.
// Assumes nxt is the table lookup for this unit's state when en is high.
module pc_phase_unit #(
    parameter int ST_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic            hit,
    input  logic [ST_W-1:0] nxt,
    output logic [ST_W-1:0] st
);
    // Hold state between own-phase updates; drop to start on a missing hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) st <= '0;
        else if (en)       st <= hit ? nxt : '0;
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(st));
    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit && !clr) |=> st == $past(nxt));
    // R4
    miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hit && !clr) |=> st == '0);
    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st == '0);
endmodule

// File: rtl/pc_confirm.sv
// Remnant alignment and output stage: for each pattern, picks the phase whose
// held state lines up with the remnant end, ANDs mask and remnant flag, and
// registers the ORed result. Assumes legal remnant lengths are 1..PHASES-1.
module pc_confirm #(
    parameter int PHASES = 3,
    parameter int PH_W   = 2,
    parameter int ST_W   = 2,
    parameter int NPAT   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sos,
    input  logic                           acc,
    input  logic [PH_W-1:0]                ph,
    input  logic [ST_W-1:0]                ph_st [PHASES],
    input  logic [NPAT-1:0]                rem_hit,
    input  logic [(1<<ST_W)-1:0][NPAT-1:0] pmask,
    input  logic [NPAT-1:0][PH_W-1:0]      rlen,
    output logic                           hit_valid,
    output logic [NPAT-1:0]                hit_vec
);
    logic [NPAT-1:0] conf;

    // Per-pattern phase selection and final AND.
    always_comb begin
        conf = '0;
        for (int p = 0; p < NPAT; p++) begin
            int d;
            d = int'(ph) + PHASES - int'(rlen[p]);
            if (d >= PHASES) d = d - PHASES;
            if (rlen[p] != '0 && int'(rlen[p]) < PHASES)
                conf[p] = rem_hit[p] & pmask[ph_st[PH_W'(d)]][p];
        end
    end

    // Register the confirmed vector one cycle after the character.
    always_ff @(posedge clk) begin
        if (!rst_n || sos) begin
            hit_valid <= 1'b0;
            hit_vec   <= '0;
        end else begin
            hit_valid <= acc;
            hit_vec   <= acc ? conf : '0;
        end
    end

    // R5
    vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> hit_valid);
    // R10
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> hit_valid);
    // R10
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !hit_valid);
    // R8
    sos_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sos |=> (!hit_valid && hit_vec == '0));
endmodule

// File: rtl/phased_seq_confirm.sv
// Top: phased confirmation of split patterns from subpattern indices and
// remnant flags. Assumes one first-stage result per character; sos marks a new
// stream and carries no character.
module phased_seq_confirm #(
    parameter int PHASES = 3,
    parameter int QIDX_W = 3,
    parameter int ST_W   = 2,
    parameter int NPAT   = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sos,
    input  logic                                  char_valid,
    input  logic                                  qhit,
    input  logic [QIDX_W-1:0]                     qidx,
    input  logic [NPAT-1:0]                       rem_hit,
    input  logic                                  cfg_we,
    input  logic [1:0]                            cfg_sel,
    input  logic [ST_W+QIDX_W-1:0]                cfg_addr,
    input  logic [((NPAT > ST_W) ? NPAT : ST_W)-1:0] cfg_data,
    output logic                                  hit_valid,
    output logic [NPAT-1:0]                       hit_vec
);
    localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam int NSTATE = 1 << ST_W;
    localparam int DW     = (NPAT > ST_W) ? NPAT : ST_W;

    logic                          acc;
    logic [PH_W-1:0]               ph;
    logic [ST_W-1:0]               ph_st [PHASES];
    logic [PHASES-1:0]             ph_en;
    logic [ST_W-1:0]               cur_st;
    logic [ST_W-1:0]               tr_next;
    logic [NSTATE-1:0][NPAT-1:0]   pmask;
    logic [NPAT-1:0][PH_W-1:0]     rlen;

    assign acc    = char_valid && !sos;
    assign cur_st = ph_st[ph];

    pc_cfg_tables #(
        .QIDX_W(QIDX_W), .ST_W(ST_W), .NPAT(NPAT), .PH_W(PH_W), .DW(DW)
    ) u_tables (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .addr(cfg_addr), .data(cfg_data),
        .tr_addr({cur_st, qidx}), .tr_next(tr_next),
        .pmask(pmask), .rlen(rlen)
    );

    pc_phase_ctr #(.PHASES(PHASES), .PH_W(PH_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(sos), .adv(acc), .ph(ph)
    );

    for (genvar k = 0; k < PHASES; k++) begin : g_phase
        assign ph_en[k] = acc && (ph == PH_W'(k));
        pc_phase_unit #(.ST_W(ST_W)) u_unit (
            .clk(clk), .rst_n(rst_n), .clr(sos), .en(ph_en[k]),
            .hit(qhit), .nxt(tr_next), .st(ph_st[k])
        );
    end

    pc_confirm #(
        .PHASES(PHASES), .PH_W(PH_W), .ST_W(ST_W), .NPAT(NPAT)
    ) u_confirm (
        .clk(clk), .rst_n(rst_n), .sos(sos), .acc(acc), .ph(ph),
        .ph_st(ph_st), .rem_hit(rem_hit), .pmask(pmask), .rlen(rlen),
        .hit_valid(hit_valid), .hit_vec(hit_vec)
    );

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ph_en));
    // R3
    step_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> $countones(ph_en) == 1);
endmodule

// File: tb/phased_seq_confirm_bench.sv
module phased_seq_confirm_bench;
    localparam int CLK_PERIOD = 10;
    localparam int F = 3;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sos = 1'b0, char_valid = 1'b0, qhit = 1'b0;
    logic [2:0] qidx = '0;
    logic [NP-1:0] rem_hit = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [4:0] cfg_addr = '0;
    logic [3:0] cfg_data = '0;
    logic hit_valid;
    logic [NP-1:0] hit_vec;

    int n_chk = 0, n_fail = 0, n_hits = 0;
    logic exp_valid = 1'b0;
    logic [NP-1:0] exp_vec = '0;
    logic pend = 1'b0;
    logic [NP-1:0] lit_vec = '0;
    string lit_tag = "";
    string tag = "R1";

    int ph_m = 0;
    logic [1:0] st_m [F];
    logic [NP-1:0] pm_m [4];
    int rl_m [NP];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    phased_seq_confirm u_phased_seq_confirm (
        .clk(clk), .rst_n(rst_n), .sos(sos), .char_valid(char_valid),
        .qhit(qhit), .qidx(qidx), .rem_hit(rem_hit), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .hit_valid(hit_valid), .hit_vec(hit_vec)
    );

    // Configured sequence rule: 1 then 2 reaches state 2; 1 starts state 1; 3 gives state 3.
    function automatic logic [1:0] tnext(logic [1:0] s, logic [2:0] q);
        if (s == 2'd1 && q == 3'd2) return 2'd2;
        if (q == 3'd1) return 2'd1;
        if (q == 3'd3) return 2'd3;
        return 2'd0;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic compare();
        n_chk++;
        if (hit_valid !== exp_valid || hit_vec !== exp_vec) begin
            n_fail++;
            $display("FAIL %s: valid/vec actual %b/%b expected %b/%b",
                     tag, hit_valid, hit_vec, exp_valid, exp_vec);
        end
        if (pend) begin
            n_chk++;
            if (hit_valid !== 1'b1 || hit_vec !== lit_vec) begin
                n_fail++;
                $display("FAIL %s: vec actual %b expected %b", lit_tag, hit_vec, lit_vec);
            end
            pend = 1'b0;
        end
    endtask

    task automatic model(logic v, logic s, logic qh, logic [2:0] qi, logic [NP-1:0] rm);
        if (s) begin
            ph_m = 0;
            for (int k = 0; k < F; k++) st_m[k] = 2'd0;
            exp_valid = 1'b0; exp_vec = '0;
        end else if (v) begin
            exp_vec = '0;
            for (int p = 0; p < NP; p++)
                if (rl_m[p] >= 1 && rl_m[p] < F)
                    exp_vec[p] = rm[p] & pm_m[st_m[(ph_m + F - rl_m[p]) % F]][p];
            if (exp_vec != '0) n_hits++;
            st_m[ph_m] = qh ? tnext(st_m[ph_m], qi) : 2'd0;
            ph_m = (ph_m + 1) % F;
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0; exp_vec = '0;
        end
    endtask

    task automatic drive(logic v, logic s, logic qh, logic [2:0] qi, logic [NP-1:0] rm);
        @(negedge clk);
        compare();
        cfg_we = 1'b0;
        char_valid = v; sos = s; qhit = qh; qidx = qi; rem_hit = rm;
        model(v, s, qh, qi, rm);
    endtask

    task automatic ch(logic qh, logic [2:0] qi, logic [NP-1:0] rm);
        drive(1'b1, 1'b0, qh, qi, rm);
    endtask

    task automatic want(logic [NP-1:0] v, string t);
        pend = 1'b1; lit_vec = v; lit_tag = t;
    endtask

    task automatic cfg_wr(logic [1:0] s, logic [4:0] a, logic [3:0] d);
        @(negedge clk);
        compare();
        char_valid = 1'b0; sos = 1'b0; qhit = 1'b0; rem_hit = '0;
        cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_data = d;
        model(1'b0, 1'b0, 1'b0, 3'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < F; k++) st_m[k] = 2'd0;
        pm_m[0] = 4'b0000; pm_m[1] = 4'b1000; pm_m[2] = 4'b0101; pm_m[3] = 4'b0010;
        rl_m[0] = 1; rl_m[1] = 2; rl_m[2] = 2; rl_m[3] = 1;
        repeat (3) @(posedge clk);
        // R1: outputs cleared by reset
        tag = "R1";
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        // R11: table loads; writes must not raise hit_valid
        tag = "R11";
        for (int a = 0; a < 32; a++) cfg_wr(2'd0, 5'(a), {2'b00, tnext(2'(a >> 3), 3'(a & 7))});
        for (int s = 0; s < 4; s++) cfg_wr(2'd1, 5'(s), pm_m[s]);
        for (int p = 0; p < NP; p++) cfg_wr(2'd2, 5'(p), 4'(rl_m[p]));
        cfg_wr(2'd3, 5'd2, 4'hF);
        // R4 R5: 1 then 2 at spacing F, remnants of length 1 and 2
        tag = "R5";
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(1, 3'd1, '0); ch(0, 3'd0, '0); ch(0, 3'd0, '0);
        ch(1, 3'd2, '0); ch(0, 3'd0, 4'b0001); want(4'b0001, "R5 remnant length 1");
        ch(0, 3'd0, 4'b0100); want(4'b0100, "R5 remnant length 2");
        // R2: idle cycles do not advance the phase
        tag = "R2";
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(1, 3'd1, '0); drive(0, 0, 0, 3'd0, '0); ch(0, 3'd0, '0);
        drive(0, 0, 0, 3'd0, '0); ch(0, 3'd0, '0); ch(1, 3'd2, '0);
        drive(0, 0, 0, 3'd0, '0); ch(0, 3'd0, 4'b0001); want(4'b0001, "R2 idle gaps");
        // R6: remnant with no matching sequence
        tag = "R6";
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(0, 3'd0, 4'b1111); want(4'b0000, "R6 bare remnant");
        // R7: wrong spacing
        tag = "R7";
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(1, 3'd1, '0); ch(0, 3'd0, '0); ch(1, 3'd2, '0);
        ch(0, 3'd0, 4'b0001); want(4'b0000, "R7 spacing 2");
        // R8: start of stream mid-sequence
        tag = "R8";
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(1, 3'd1, '0); ch(0, 3'd0, '0); ch(0, 3'd0, '0);
        drive(1'b1, 1'b1, 1'b1, 3'd2, 4'b1111);
        ch(1, 3'd2, '0); ch(0, 3'd0, 4'b0001); want(4'b0000, "R8 cleared sequence");
        // R9: two phases confirm on one character
        tag = "R9";
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(1, 3'd3, '0); ch(1, 3'd1, '0); ch(0, 3'd0, 4'b1010); want(4'b1010, "R9 OR of phases");
        // R3: other-phase hits between own-phase steps
        tag = "R3";
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(1, 3'd1, '0); ch(1, 3'd3, '0); ch(1, 3'd1, '0);
        ch(1, 3'd2, '0); ch(0, 3'd0, 4'b0001); want(4'b0001, "R3 phases independent");
        // R10 R5: pseudo-random stream against the phase model
        tag = "R10";
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[2:0] != 3'd0, lfsr[15:11] == 5'd0, lfsr[3],
                  {1'b0, lfsr[5:4]}, lfsr[9:6] & lfsr[13:10]);
        end
        n_chk++;
        if (n_hits == 0) begin
            n_fail++;
            $display("FAIL R5: random hits actual 0 expected >0");
        end
        // R6: remnant length 0 disables pattern 3
        tag = "R6";
        cfg_wr(2'd2, 5'd3, 4'd0); rl_m[3] = 0;
        drive(1'b0, 1'b1, 1'b0, 3'd0, '0);
        ch(1, 3'd3, '0); ch(1, 3'd1, '0); ch(0, 3'd0, 4'b1010); want(4'b0010, "R6 length 0");
        drive(0, 0, 0, 3'd0, '0);
        @(negedge clk);
        compare();
        summary();
    end
endmodule